// File: doc/BRIEF.md
# Power Mode Sequencer

This block decides which power mode the device is in and drives the enables for each power domain from that decision. It has four modes: full operation, a standby mode in which only the wake-source logic remains powered, a USB suspend mode in which only the low-frequency oscillator keeps running, and a hard power-down mode in which every clock is stopped. Software requests standby and hard power-down. Suspend is entered without software involvement once the USB bus has been silent for longer than a configured time. That time is counted in ticks of the low-frequency clock, which arrive as a one-cycle strobe on `lf_tick`.

Each low-power mode has its own set of wake sources. Any activity on a communication interface ends standby. Suspend ends on USB or host-interface activity or on the wake pin, but never on activity from the master interfaces. Hard power-down ends only on the wake pin or on reset. Leaving a low-power mode is a fixed three-step sequence: the system clock is enabled first, the main regulator goes back to full-power mode one cycle later, and the return to full operation is reported one cycle after that.

Analog regulators, oscillators and the USB PHY are outside the block. It drives only their enable and mode controls.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the block is in full operation. `mode_o` is 2'b00, `waking_o` is 0, `sys_clk_en`, `lf_clk_en` and `wake_pwr_en` are 1, and `mreg_lp` is 0.
- R2: In hard power-down, `mode_o` is 2'b11. `sys_clk_en`, `lf_clk_en` and `wake_pwr_en` are 0, and `mreg_lp` is 1.
- R3: In standby, `mode_o` is 2'b01. `sys_clk_en` is 0, `mreg_lp` is 1, and `lf_clk_en` and `wake_pwr_en` stay 1.
- R4: In USB suspend, `mode_o` is 2'b10. `sys_clk_en` is 0, `lf_clk_en` is 1, `mreg_lp` is 1 (default `SUSP_MREG_LP`), and `wake_pwr_en` is 1.
- R5: A `sw_req` strobe in full operation moves the block to the mode given by `sw_mode`. Code 2'b01 selects standby and code 2'b11 selects hard power-down, and the new mode appears one cycle later. The codes 2'b00 and 2'b10 are ignored, and so is any request made outside full operation.
- R6: When `usb_sel` is 1 and the block is in full operation, the block enters USB suspend on the first `lf_tick` that arrives after IDLE_TICKS = LF_CLK_HZ*IDLE_US/10^6 silent ticks (1095 by default). A `usb_act` pulse restarts the count from zero. When `usb_sel` is 0, suspend is never entered.
- R7: Standby is left on `usb_act`, `host_act`, `mst_act` or `ext_wake`.
- R8: USB suspend is left on `usb_act`, `host_act` or `ext_wake`. `mst_act` has no effect in this mode.
- R9: Hard power-down is left only on `ext_wake`. The other activity inputs and `lf_tick` have no effect.
- R10: A wake event seen at a clock edge starts the exit sequence, and `mode_o` keeps the code of the mode being left until full operation is reported:
  - After that edge, `waking_o` and `sys_clk_en` are 1 and `mreg_lp` is still 1.
  - One cycle later, `mreg_lp` drops to 0.
  - One cycle after that, `waking_o` is 0 and `mode_o` is 2'b00.
- R11: If a software request for standby or hard power-down arrives in the same cycle as the suspend timeout, the software request wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lf_tick | input | 1 | One-cycle strobe per low-frequency clock period |
| usb_sel | input | 1 | Host link is USB; enables automatic suspend |
| usb_act | input | 1 | USB bus activity seen |
| host_act | input | 1 | Activity on the I2C, SPI or UART host link |
| mst_act | input | 1 | Activity on a master interface |
| ext_wake | input | 1 | External wake pin |
| sw_req | input | 1 | Software mode request strobe |
| sw_mode | input | 2 | Requested mode code |
| sys_clk_en | output | 1 | System clock enable |
| lf_clk_en | output | 1 | Low-frequency oscillator enable |
| mreg_lp | output | 1 | Main regulator low-power mode |
| wake_pwr_en | output | 1 | Power for the wake-source logic |
| mode_o | output | 2 | Current mode code |
| waking_o | output | 1 | Exit sequence in progress |

## Verification
The hardest condition to reach from the ports is the exact edge of the suspend window, and in particular the case where that edge coincides with a software request. To get there, the bench holds `lf_tick` high on every clock so that the count advances once per cycle. It then stops after exactly IDLE_TICKS ticks, so the next tick is the one that expires. At that point the bench either allows one more tick, or applies that tick together with a software request. A `usb_act` pulse placed partway through a count shows that the full window must elapse again after the restart.

// File: rtl/pms_pkg.sv
package pms_pkg;

   typedef enum logic [2:0] {
      ST_ACTIVE = 3'd0,
      ST_STBY   = 3'd1,
      ST_SUSP   = 3'd2,
      ST_HPD    = 3'd3,
      ST_WCLK   = 3'd4,
      ST_WREG   = 3'd5
   } pms_state_e;

   localparam logic [1:0] MODE_ACTIVE = 2'b00;
   localparam logic [1:0] MODE_STBY   = 2'b01;
   localparam logic [1:0] MODE_SUSP   = 2'b10;
   localparam logic [1:0] MODE_HPD    = 2'b11;

   typedef struct packed {
      logic sys_clk;
      logic lf_clk;
      logic mreg_lp;
      logic wake_pwr;
   } pms_dom_t;

endpackage

// File: rtl/pms_idle_timer.sv
// USB bus silence counter, advanced by low-frequency clock strobes.
module pms_idle_timer #(
   parameter int LF_CLK_HZ = 365000,
   parameter int IDLE_US   = 3000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic lf_tick,
   input  logic usb_act,
   output logic expire
);
   localparam longint TICKS_L    = (longint'(LF_CLK_HZ) * longint'(IDLE_US)) / 64'd1000000;
   localparam int     IDLE_TICKS = int'(TICKS_L);
   localparam int     CW         = $clog2(IDLE_TICKS + 1);
   localparam logic [CW-1:0] LIMIT = CW'(IDLE_TICKS);

   if (IDLE_TICKS < 1) begin : g_bad_cfg
      $error("pms_idle_timer: idle window shorter than one low-frequency tick");
   end

   logic [CW-1:0] cnt_q;
   logic          at_limit;

   assign at_limit = (cnt_q == LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || usb_act) begin
         cnt_q <= '0;
      end else if (lf_tick && !at_limit) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expire = run & lf_tick & ~usb_act & at_limit;

endmodule

// File: rtl/pms_wake_src.sv
// Groups activity inputs into the wake condition of each low-power mode.
module pms_wake_src #(
   parameter bit STBY_MST_WAKE = 1'b1
) (
   input  logic usb_act,
   input  logic host_act,
   input  logic mst_act,
   input  logic ext_wake,
   output logic wake_stby,
   output logic wake_susp,
   output logic wake_hpd
);
   logic link_act;
   assign link_act = usb_act | host_act | ext_wake;

   if (STBY_MST_WAKE) begin : g_stby_all
      assign wake_stby = link_act | mst_act;
   end else begin : g_stby_link
      logic unused_mst;
      assign unused_mst = mst_act;
      assign wake_stby  = link_act;
   end

   assign wake_susp = link_act;
   assign wake_hpd  = ext_wake;

endmodule

// File: rtl/pms_fsm.sv
// Mode state machine with a fixed two-step exit sequence.
module pms_fsm
   import pms_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sw_req,
   input  logic [1:0] sw_mode,
   input  logic       idle_expire,
   input  logic       wake_stby,
   input  logic       wake_susp,
   input  logic       wake_hpd,
   output pms_state_e state_o,
   output logic [1:0] last_lp_o
);
   pms_state_e state_q, state_d;
   logic [1:0] last_q, last_d;

   always_comb begin
      state_d = state_q;
      last_d  = last_q;
      unique case (state_q)
         ST_ACTIVE: begin
            if (sw_req && sw_mode == MODE_STBY) begin
               state_d = ST_STBY;
               last_d  = MODE_STBY;
            end else if (sw_req && sw_mode == MODE_HPD) begin
               state_d = ST_HPD;
               last_d  = MODE_HPD;
            end else if (idle_expire) begin
               state_d = ST_SUSP;
               last_d  = MODE_SUSP;
            end
         end
         ST_STBY: if (wake_stby) state_d = ST_WCLK;
         ST_SUSP: if (wake_susp) state_d = ST_WCLK;
         ST_HPD:  if (wake_hpd)  state_d = ST_WCLK;
         ST_WCLK: state_d = ST_WREG;
         ST_WREG: state_d = ST_ACTIVE;
         default: state_d = ST_ACTIVE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_ACTIVE;
         last_q  <= MODE_ACTIVE;
      end else begin
         state_q <= state_d;
         last_q  <= last_d;
      end
   end

   assign state_o   = state_q;
   assign last_lp_o = last_q;

endmodule

// File: rtl/pms_dom_decode.sv
// Maps the state to per-domain enables and the reported mode.
module pms_dom_decode
   import pms_pkg::*;
#(
   parameter bit SUSP_MREG_LP = 1'b1
) (
   input  pms_state_e state,
   input  logic [1:0] last_lp,
   output pms_dom_t   dom,
   output logic [1:0] mode,
   output logic       waking
);
   logic susp_lp;

   if (SUSP_MREG_LP) begin : g_susp_lp
      assign susp_lp = 1'b1;
   end else begin : g_susp_full
      assign susp_lp = 1'b0;
   end

   always_comb begin
      dom    = '{sys_clk: 1'b1, lf_clk: 1'b1, mreg_lp: 1'b0, wake_pwr: 1'b1};
      mode   = MODE_ACTIVE;
      waking = 1'b0;
      unique case (state)
         ST_ACTIVE: ;
         ST_STBY: begin
            dom  = '{sys_clk: 1'b0, lf_clk: 1'b1, mreg_lp: 1'b1, wake_pwr: 1'b1};
            mode = MODE_STBY;
         end
         ST_SUSP: begin
            dom  = '{sys_clk: 1'b0, lf_clk: 1'b1, mreg_lp: susp_lp, wake_pwr: 1'b1};
            mode = MODE_SUSP;
         end
         ST_HPD: begin
            dom  = '{sys_clk: 1'b0, lf_clk: 1'b0, mreg_lp: 1'b1, wake_pwr: 1'b0};
            mode = MODE_HPD;
         end
         ST_WCLK: begin
            dom    = '{sys_clk: 1'b1, lf_clk: 1'b1, mreg_lp: 1'b1, wake_pwr: 1'b1};
            mode   = last_lp;
            waking = 1'b1;
         end
         ST_WREG: begin
            dom    = '{sys_clk: 1'b1, lf_clk: 1'b1, mreg_lp: 1'b0, wake_pwr: 1'b1};
            mode   = last_lp;
            waking = 1'b1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
   import pms_pkg::*;
#(
   parameter int LF_CLK_HZ     = 365000,
   parameter int IDLE_US       = 3000,
   parameter bit STBY_MST_WAKE = 1'b1,
   parameter bit SUSP_MREG_LP  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       lf_tick,
   input  logic       usb_sel,
   input  logic       usb_act,
   input  logic       host_act,
   input  logic       mst_act,
   input  logic       ext_wake,
   input  logic       sw_req,
   input  logic [1:0] sw_mode,
   output logic       sys_clk_en,
   output logic       lf_clk_en,
   output logic       mreg_lp,
   output logic       wake_pwr_en,
   output logic [1:0] mode_o,
   output logic       waking_o
);
   pms_state_e state;
   logic [1:0] last_lp;
   logic       idle_expire, timer_run;
   logic       wake_stby, wake_susp, wake_hpd;
   pms_dom_t   dom;

   assign timer_run = usb_sel & (state == ST_ACTIVE);

   pms_idle_timer #(
      .LF_CLK_HZ (LF_CLK_HZ),
      .IDLE_US   (IDLE_US)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (timer_run),
      .lf_tick (lf_tick),
      .usb_act (usb_act),
      .expire  (idle_expire)
   );

   pms_wake_src #(
      .STBY_MST_WAKE (STBY_MST_WAKE)
   ) u_wake (
      .usb_act   (usb_act),
      .host_act  (host_act),
      .mst_act   (mst_act),
      .ext_wake  (ext_wake),
      .wake_stby (wake_stby),
      .wake_susp (wake_susp),
      .wake_hpd  (wake_hpd)
   );

   pms_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .sw_req      (sw_req),
      .sw_mode     (sw_mode),
      .idle_expire (idle_expire),
      .wake_stby   (wake_stby),
      .wake_susp   (wake_susp),
      .wake_hpd    (wake_hpd),
      .state_o     (state),
      .last_lp_o   (last_lp)
   );

   pms_dom_decode #(
      .SUSP_MREG_LP (SUSP_MREG_LP)
   ) u_dec (
      .state   (state),
      .last_lp (last_lp),
      .dom     (dom),
      .mode    (mode_o),
      .waking  (waking_o)
   );

   assign sys_clk_en  = dom.sys_clk;
   assign lf_clk_en   = dom.lf_clk;
   assign mreg_lp     = dom.mreg_lp;
   assign wake_pwr_en = dom.wake_pwr;

endmodule

// File: rtl/pms_checker.sv
module pms_checker
   import pms_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       usb_act,
   input logic       host_act,
   input logic       ext_wake,
   input logic       sw_req,
   input logic [1:0] sw_mode,
   input logic       sys_clk_en,
   input logic       lf_clk_en,
   input logic       mreg_lp,
   input logic       wake_pwr_en,
   input logic [1:0] mode_o,
   input logic       waking_o
);
   a_r2_hpd_domains: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == MODE_HPD && !waking_o) |-> (!sys_clk_en && !lf_clk_en && mreg_lp && !wake_pwr_en));

   a_r3_stby_domains: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == MODE_STBY && !waking_o) |-> (!sys_clk_en && mreg_lp && wake_pwr_en && lf_clk_en));

   a_r4_susp_clocks: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == MODE_SUSP && !waking_o) |-> (!sys_clk_en && lf_clk_en));

   a_r5_stby_by_sw: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == MODE_STBY && !waking_o && $past(mode_o) == MODE_ACTIVE && !$past(waking_o))
      |-> ($past(sw_req) && $past(sw_mode) == MODE_STBY));

   a_r8_master_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == MODE_SUSP && !waking_o && !usb_act && !host_act && !ext_wake)
      |=> (mode_o == MODE_SUSP && !waking_o));

   a_r9_hpd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == MODE_HPD && !waking_o && !ext_wake) |=> (mode_o == MODE_HPD && !waking_o));

   a_r10_clock_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_clk_en) |-> (mreg_lp && waking_o));

   a_r10_reg_then_active: assert property (@(posedge clk) disable iff (!rst_n)
      (waking_o && !mreg_lp) |=> (!waking_o && mode_o == MODE_ACTIVE));

endmodule

bind pwr_mode_seq pms_checker u_pms_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .usb_act     (usb_act),
   .host_act    (host_act),
   .ext_wake    (ext_wake),
   .sw_req      (sw_req),
   .sw_mode     (sw_mode),
   .sys_clk_en  (sys_clk_en),
   .lf_clk_en   (lf_clk_en),
   .mreg_lp     (mreg_lp),
   .wake_pwr_en (wake_pwr_en),
   .mode_o      (mode_o),
   .waking_o    (waking_o)
);

// File: tb/pwr_mode_seq_bench.sv
module pwr_mode_seq_bench;
   localparam int CLK_PERIOD = 10;
   localparam int LF_HZ      = 365000;
   localparam int WIN_US     = 3000;
   localparam int IDLE_TICKS = (LF_HZ / 1000) * WIN_US / 1000;
   localparam int WDOG_LIMIT = 150000;

   localparam logic [1:0] M_ACT = 2'b00, M_STBY = 2'b01, M_SUSP = 2'b10, M_HPD = 2'b11;
   localparam logic [3:0] D_ACT = 4'b1101, D_LP = 4'b0111, D_HPD = 4'b0010,
                          D_WCLK = 4'b1111, D_WREG = 4'b1101;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lf_tick = 1'b0, usb_sel = 1'b0, usb_act = 1'b0, host_act = 1'b0;
   logic mst_act = 1'b0, ext_wake = 1'b0, sw_req = 1'b0;
   logic [1:0] sw_mode = 2'b00;
   logic sys_clk_en, lf_clk_en, mreg_lp, wake_pwr_en, waking_o;
   logic [1:0] mode_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   pwr_mode_seq #(.LF_CLK_HZ(LF_HZ), .IDLE_US(WIN_US)) u_pwr_mode_seq (
      .clk(clk), .rst_n(rst_n), .lf_tick(lf_tick), .usb_sel(usb_sel),
      .usb_act(usb_act), .host_act(host_act), .mst_act(mst_act),
      .ext_wake(ext_wake), .sw_req(sw_req), .sw_mode(sw_mode),
      .sys_clk_en(sys_clk_en), .lf_clk_en(lf_clk_en), .mreg_lp(mreg_lp),
      .wake_pwr_en(wake_pwr_en), .mode_o(mode_o), .waking_o(waking_o)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles == WDOG_LIMIT) begin
         errors = errors + 1;
         $display("FAIL watchdog: got %0d cycles expected completion", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   function automatic logic [6:0] obs(input logic [1:0] m, input logic w, input logic [3:0] d);
      return {m, w, d};
   endfunction

   task automatic check(input string req, input logic [6:0] exp);
      logic [6:0] act;
      act = {mode_o, waking_o, sys_clk_en, lf_clk_en, mreg_lp, wake_pwr_en};
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: got %b expected %b", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      lf_tick = 0; usb_sel = 0; usb_act = 0; host_act = 0;
      mst_act = 0; ext_wake = 0; sw_req = 0; sw_mode = 2'b00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic sw_go(input logic [1:0] m);
      sw_req = 1'b1; sw_mode = m;
      @(negedge clk);
      sw_req = 1'b0; sw_mode = 2'b00;
   endtask

   task automatic ticks(input int n);
      lf_tick = 1'b1;
      repeat (n) @(negedge clk);
      lf_tick = 1'b0;
   endtask

   task automatic pulse(input int src);
      case (src)
         0: usb_act = 1'b1;
         1: host_act = 1'b1;
         2: mst_act = 1'b1;
         default: ext_wake = 1'b1;
      endcase
      @(negedge clk);
      usb_act = 0; host_act = 0; mst_act = 0; ext_wake = 0;
   endtask

   // Wake source pulse, then the R10 exit steps one cycle apart.
   task automatic wake_check(input int src, input logic [1:0] from, input string req);
      pulse(src);
      check("R10 clock step", obs(from, 1'b1, D_WCLK));
      @(negedge clk);
      check("R10 regulator step", obs(from, 1'b1, D_WREG));
      @(negedge clk);
      check(req, obs(M_ACT, 1'b0, D_ACT));
   endtask

   task automatic t_reset();
      do_reset();
      check("R1 reset state", obs(M_ACT, 1'b0, D_ACT));
   endtask

   task automatic t_sw_modes();
      do_reset();
      sw_go(2'b00);
      check("R5 code 00 ignored", obs(M_ACT, 1'b0, D_ACT));
      sw_go(2'b10);
      check("R5 code 10 ignored", obs(M_ACT, 1'b0, D_ACT));
      sw_go(M_STBY);
      check("R3 standby domains", obs(M_STBY, 1'b0, D_LP));
      sw_go(M_HPD);
      check("R5 request outside active ignored", obs(M_STBY, 1'b0, D_LP));
      wake_check(1, M_STBY, "R7 host wakes standby");
      sw_go(M_HPD);
      check("R2 hard power-down domains", obs(M_HPD, 1'b0, D_HPD));
   endtask

   task automatic t_hpd();
      do_reset();
      sw_go(M_HPD);
      for (int s = 0; s < 3; s++) begin
         pulse(s);
         check("R9 activity ignored in power-down", obs(M_HPD, 1'b0, D_HPD));
      end
      usb_sel = 1'b1;
      ticks(IDLE_TICKS + 5);
      check("R9 ticks ignored in power-down", obs(M_HPD, 1'b0, D_HPD));
      wake_check(3, M_HPD, "R9 wake pin ends power-down");
   endtask

   task automatic t_auto_susp();
      do_reset();
      usb_sel = 1'b1;
      ticks(IDLE_TICKS);
      check("R6 no suspend at window end", obs(M_ACT, 1'b0, D_ACT));
      ticks(1);
      check("R4 suspend domains", obs(M_SUSP, 1'b0, D_LP));
      mst_act = 1'b1;
      repeat (5) @(negedge clk);
      mst_act = 1'b0;
      check("R8 master activity ignored", obs(M_SUSP, 1'b0, D_LP));
      wake_check(1, M_SUSP, "R8 host wakes suspend");
      ticks(IDLE_TICKS + 1);
      check("R6 timer restarts after wake", obs(M_SUSP, 1'b0, D_LP));
      wake_check(0, M_SUSP, "R8 usb wakes suspend");
      ticks(IDLE_TICKS + 1);
      check("R6 suspend again", obs(M_SUSP, 1'b0, D_LP));
      wake_check(3, M_SUSP, "R8 wake pin ends suspend");
   endtask

   task automatic t_activity_clears();
      do_reset();
      usb_sel = 1'b1;
      ticks(1000);
      usb_act = 1'b1; lf_tick = 1'b1;
      @(negedge clk);
      usb_act = 1'b0; lf_tick = 1'b0;
      ticks(IDLE_TICKS);
      check("R6 usb activity restarts count", obs(M_ACT, 1'b0, D_ACT));
      ticks(1);
      check("R6 suspend after full window", obs(M_SUSP, 1'b0, D_LP));
   endtask

   task automatic t_usb_off();
      do_reset();
      usb_sel = 1'b0;
      ticks(2 * IDLE_TICKS);
      check("R6 no suspend without usb host", obs(M_ACT, 1'b0, D_ACT));
   endtask

   task automatic t_stby_sources();
      for (int s = 0; s < 4; s++) begin
         do_reset();
         sw_go(M_STBY);
         check("R3 standby entered", obs(M_STBY, 1'b0, D_LP));
         wake_check(s, M_STBY, "R7 source wakes standby");
      end
   endtask

   task automatic t_priority();
      do_reset();
      usb_sel = 1'b1;
      ticks(IDLE_TICKS);
      lf_tick = 1'b1;
      sw_go(M_STBY);
      lf_tick = 1'b0;
      check("R11 standby request beats timeout", obs(M_STBY, 1'b0, D_LP));
      do_reset();
      usb_sel = 1'b1;
      ticks(IDLE_TICKS);
      lf_tick = 1'b1;
      sw_go(M_HPD);
      lf_tick = 1'b0;
      check("R11 power-down request beats timeout", obs(M_HPD, 1'b0, D_HPD));
   endtask

   initial begin
      t_reset();
      t_sw_modes();
      t_hpd();
      t_auto_susp();
      t_activity_clears();
      t_usb_off();
      t_stby_sources();
      t_priority();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule